// File: doc/BRIEF.md
# Ring Register Bus Controller

This block is the bus master for an 8-bit register bus. Up to sixteen peripheral slots share the bus. The data path is not multiplexed. The controller drives a byte into the head of a daisy chain, and every slot that is not selected hands that byte on unchanged. The selected slot replaces the byte with its read data. The byte that arrives at the tail of the chain is what the controller samples as read data. Each slot has its own strobe line, and it returns its own acknowledge and stall lines.

On the host side the controller accepts one command descriptor at a time. A descriptor holds the direction, the address mode (incrementing or fixed), the slot, the first register address and the byte count. For a write, the data bytes come in on a separate valid/ready stream. Every command produces a byte stream back to the host. The stream is a command byte, the start address, any read data, and a final byte giving the number of bus cycles that were acknowledged. A burst stops at the first byte that is not acknowledged, so a host filling or draining a slot's FIFO learns how far it got.

When no command is waiting, the controller polls the slots in round-robin order. A poll asks the slot how many bytes it has for the host. A nonzero reply starts an internal read of that many registers, beginning at register 0. The result goes to the host as an unsolicited packet.

Top module: `ring_bus_ctrl`

## Requirements
- R1: A register cycle raises exactly one strobe, the one for the target slot, with the tag high. The write line follows the command direction. During a write cycle, the byte drawn from the write stream is driven on `bus_dat_o`.
- R2: With no command pending, the controller issues polls. A poll is a read with the tag low and address 0. Successive polls go to slots 0,1,2,…,15,0,… in turn.
- R3: A command presented while the controller is polling is accepted at the next idle cycle, before any further poll. Polling then resumes after the command's packet.
- R4: While the selected slot holds its stall line high, the strobe, address and outgoing data stay unchanged. The cycle completes on the first clock with stall low.
- R5: If stall stays high for 16 consecutive clocks, the controller abandons the cycle as unacknowledged. The burst ends, and the count so far is reported.
- R6: In incrementing mode the address rises by one after each acknowledged byte and wraps from 0xFF to 0x00. In fixed mode every cycle uses the start address.
- R7: A read or write burst ends at the first cycle completed without acknowledge. For a write, the rest of that command's write bytes are still taken from the stream and discarded.
- R8: The reply to a host command has this byte order: the command byte, then the start address, then the acknowledged read bytes in bus order, then the acknowledged count. The command byte is bit7=1, bit6=write, bit5=increment, bit4=0, bits3:0=slot. A write reply carries no data bytes.
- R9: A nonzero poll reply N starts a read of up to N registers from address 0, incrementing. It is reported with command byte bit7=0, bit6=0, bit5=1, and the slot in bits3:0, followed by address 0x00, the data and the count. A zero reply produces nothing.
- R10: A poll abandoned by the stall limit is treated as a zero reply and produces no output.
- R11: A command with length 0 runs no bus cycle and returns the command byte, the address and a count of 0.
- R12: After reset no strobe is active, no output byte is valid, and a command is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command descriptor valid |
| cmd_ready_o | output | 1 | Command accepted this cycle |
| cmd_write_i | input | 1 | 1 = write burst, 0 = read burst |
| cmd_incr_i | input | 1 | 1 = incrementing address, 0 = fixed |
| cmd_slot_i | input | 4 | Target slot |
| cmd_addr_i | input | 8 | First register address |
| cmd_len_i | input | 8 | Byte count |
| wr_valid_i | input | 1 | Write byte valid |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write byte taken |
| rsp_valid_o | output | 1 | Output byte valid (one-cycle pulse) |
| rsp_data_o | output | 8 | Output byte |
| bus_stb_o | output | 16 | One strobe per slot |
| bus_we_o | output | 1 | Bus write |
| bus_tag_o | output | 1 | 1 = register cycle, 0 = poll |
| bus_addr_o | output | 8 | Register address |
| bus_dat_o | output | 8 | Byte into the head of the ring |
| bus_dat_i | input | 8 | Byte returned from the tail of the ring |
| bus_stall_i | input | 16 | Per-slot stall |
| bus_ack_i | input | 16 | Per-slot acknowledge |

## Verification
Most faults in the burst state show up within one packet. A count register that is off by one changes the trailing count byte. A wrong address step changes the read data, or the memory contents that a later read returns. A wrong decision at an unacknowledged cycle either misaligns the next command's write stream or leaves the packet incomplete, and both are visible within a few hundred clocks. A broken poll pointer or a broken stall limit shows up on the strobe lines within one rotation of polls.

// File: rtl/ring_bus_pkg.sv
package ring_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_HDR, ST_ADR, ST_WGET, ST_CYC, ST_DRAIN, ST_TRAIL
  } ring_st_e;

  function automatic logic [7:0] cmd_byte(input logic is_rsp, input logic we,
                                          input logic incr, input logic [3:0] slot);
    return {is_rsp, we, incr, 1'b0, slot};
  endfunction
endpackage

// File: rtl/ring_stall_timer.sv
module ring_stall_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic stall_i,
  input  logic ack_i,
  output logic done_o,
  output logic acked_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic tmo;

  assign tmo     = stall_i && (cnt_q == LAST);
  assign done_o  = active_i && (!stall_i || tmo);
  assign acked_o = active_i && !stall_i && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || done_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_TMO_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && stall_i && cnt_q == LAST) |-> done_o && !acked_o); // R5
endmodule

// File: rtl/ring_poll_rr.sv
module ring_poll_rr #(
  parameter int NSLOT = 16,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [SW-1:0] slot_o
);
  localparam logic [SW-1:0] TOP = SW'(NSLOT - 1);

  logic [SW-1:0] ptr_q;

  assign slot_o = (ptr_q == TOP) ? '0 : ptr_q + SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= TOP;
    else if (adv_i) ptr_q <= slot_o;
  end
endmodule

// File: rtl/ring_bus_ctrl.sv
module ring_bus_ctrl
  import ring_bus_pkg::*;
#(
  parameter int NSLOT       = 16,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int LW          = 8,
  parameter int STALL_LIMIT = 16,
  localparam int SW         = $clog2(NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_write_i,
  input  logic             cmd_incr_i,
  input  logic [SW-1:0]    cmd_slot_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [LW-1:0]    cmd_len_i,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             wr_ready_o,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_data_o,
  output logic [NSLOT-1:0] bus_stb_o,
  output logic             bus_we_o,
  output logic             bus_tag_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_dat_o,
  input  logic [DW-1:0]    bus_dat_i,
  input  logic [NSLOT-1:0] bus_stall_i,
  input  logic [NSLOT-1:0] bus_ack_i
);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  ring_st_e      st_q;
  logic [SW-1:0] slot_q;
  logic          we_q, incr_q, auto_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q, cnt_q;
  logic [DW-1:0] wbyte_q;

  logic          cyc_active, cyc_done, cyc_acked;
  logic          sel_stall, sel_ack;
  logic          rr_adv;
  logic [SW-1:0] rr_slot;
  logic [DW-1:0] poll_reply;

  assign cyc_active = (st_q == ST_POLL) || (st_q == ST_CYC);
  assign sel_stall  = bus_stall_i[slot_q];
  assign sel_ack    = bus_ack_i[slot_q];
  assign poll_reply = sel_stall ? '0 : bus_dat_i;   // abandoned poll counts as empty
  assign rr_adv     = (st_q == ST_IDLE) && !cmd_valid_i;

  ring_stall_timer #(.LIMIT(STALL_LIMIT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (cyc_active),
    .stall_i  (sel_stall),
    .ack_i    (sel_ack),
    .done_o   (cyc_done),
    .acked_o  (cyc_acked)
  );

  ring_poll_rr #(.NSLOT(NSLOT), .SW(SW)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (rr_adv),
    .slot_o (rr_slot)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_stb
    assign bus_stb_o[g] = cyc_active && (slot_q == SW'(g));
  end

  assign bus_tag_o   = (st_q == ST_CYC);
  assign bus_we_o    = (st_q == ST_CYC) && we_q;
  assign bus_addr_o  = (st_q == ST_POLL) ? '0 : addr_q;
  assign bus_dat_o   = ((st_q == ST_CYC) && we_q) ? wbyte_q : '0;
  assign cmd_ready_o = (st_q == ST_IDLE);
  assign wr_ready_o  = (st_q == ST_WGET) || (st_q == ST_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      slot_q      <= '0;
      we_q        <= 1'b0;
      incr_q      <= 1'b0;
      auto_q      <= 1'b0;
      addr_q      <= '0;
      left_q      <= '0;
      cnt_q       <= '0;
      wbyte_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            slot_q <= cmd_slot_i;
            we_q   <= cmd_write_i;
            incr_q <= cmd_incr_i;
            addr_q <= cmd_addr_i;
            left_q <= cmd_len_i;
            cnt_q  <= '0;
            auto_q <= 1'b0;
            st_q   <= ST_HDR;
          end else begin
            slot_q <= rr_slot;
            st_q   <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (cyc_done) begin
            if (poll_reply != '0) begin
              auto_q <= 1'b1;
              we_q   <= 1'b0;
              incr_q <= 1'b1;
              addr_q <= '0;
              left_q <= LW'(poll_reply);
              cnt_q  <= '0;
              st_q   <= ST_HDR;
            end else begin
              st_q   <= ST_IDLE;
            end
          end
        end
        ST_HDR: begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= DW'(cmd_byte(!auto_q, we_q, incr_q, 4'(slot_q)));
          st_q        <= ST_ADR;
        end
        ST_ADR: begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= DW'(addr_q);
          if (left_q == '0) st_q <= ST_TRAIL;
          else if (we_q)    st_q <= ST_WGET;
          else              st_q <= ST_CYC;
        end
        ST_WGET: begin
          if (wr_valid_i) begin
            wbyte_q <= wr_data_i;
            st_q    <= ST_CYC;
          end
        end
        ST_CYC: begin
          if (cyc_done) begin
            left_q <= left_q - ONE_L;
            if (cyc_acked) begin
              cnt_q <= cnt_q + ONE_L;
              if (incr_q) addr_q <= addr_q + AW'(1);
              if (!we_q) begin
                rsp_valid_o <= 1'b1;
                rsp_data_o  <= bus_dat_i;
              end
              if (left_q == ONE_L) st_q <= ST_TRAIL;
              else if (we_q)       st_q <= ST_WGET;
            end else if (we_q && left_q != ONE_L) begin
              st_q <= ST_DRAIN;    // discard the rest of this command's write bytes
            end else begin
              st_q <= ST_TRAIL;
            end
          end
        end
        ST_DRAIN: begin
          if (wr_valid_i) begin
            left_q <= left_q - ONE_L;
            if (left_q == ONE_L) st_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= DW'(cnt_q);
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_stb_o)); // R1
  AST_POLL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|bus_stb_o) && !bus_tag_o) |-> (!bus_we_o && bus_addr_o == '0)); // R2
  AST_HOST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> (bus_stb_o == '0)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|bus_stb_o) && sel_stall && !cyc_done) |=>
      ($stable(bus_stb_o) && $stable(bus_addr_o) && $stable(bus_dat_o))); // R4
  AST_NO_DUAL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ready_o && (|bus_stb_o))); // R7
endmodule

// File: tb/ring_bus_ctrl_tb.sv
module ring_bus_ctrl_tb;
  localparam int NS = 16;

  typedef struct packed {
    logic       we;
    logic       incr;
    logic [3:0] slot;
    logic [7:0] addr;
    logic [7:0] len;
    logic [7:0] ack;
    logic [4:0] stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'd3,  8'h10, 8'd4, 8'd255, 5'd0},
    '{1'b0, 1'b1, 4'd3,  8'h10, 8'd4, 8'd255, 5'd0},
    '{1'b1, 1'b0, 4'd5,  8'h40, 8'd6, 8'd3,   5'd0},
    '{1'b0, 1'b0, 4'd5,  8'h40, 8'd5, 8'd2,   5'd2},
    '{1'b0, 1'b1, 4'd15, 8'hFE, 8'd4, 8'd255, 5'd1},
    '{1'b1, 1'b1, 4'd0,  8'hFF, 8'd2, 8'd255, 5'd3},
    '{1'b0, 1'b1, 4'd7,  8'h00, 8'd0, 8'd255, 5'd0},
    '{1'b1, 1'b1, 4'd9,  8'h20, 8'd3, 8'd255, 5'd20}
  };
  string vtag [NV] = '{"R1 R8", "R8 R6", "R7", "R4 R7", "R6 R4", "R6", "R11", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_incr = 1'b0;
  logic [3:0]    cmd_slot = '0;
  logic [7:0]    cmd_addr = '0, cmd_len = '0;
  logic          wr_valid, wr_ready;
  logic [7:0]    wr_data;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic [NS-1:0] bus_stb, bus_stall, bus_ack;
  logic          bus_we, bus_tag;
  logic [7:0]    bus_addr, bus_dat_o, ring_ret;

  ring_bus_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_incr_i(cmd_incr), .cmd_slot_i(cmd_slot), .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .bus_stb_o(bus_stb), .bus_we_o(bus_we), .bus_tag_o(bus_tag), .bus_addr_o(bus_addr),
    .bus_dat_o(bus_dat_o), .bus_dat_i(ring_ret), .bus_stall_i(bus_stall), .bus_ack_i(bus_ack)
  );

  // slot models
  logic [7:0] mem     [NS][256];
  logic [7:0] exp_mem [NS][256];
  logic [7:0] poll_rep [NS];
  int stall_n = 0, acks_left = 255, scnt = 0;
  logic       sel_hit, m_stall;
  logic [3:0] sel_idx;

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int s = 0; s < NS; s++) if (bus_stb[s]) begin sel_hit = 1'b1; sel_idx = 4'(s); end
    m_stall   = sel_hit && (scnt < stall_n);
    bus_stall = '0;
    bus_ack   = '0;
    if (sel_hit) begin
      bus_stall[sel_idx] = m_stall;
      bus_ack[sel_idx]   = !m_stall && bus_tag && (acks_left > 0);
    end
    if (!sel_hit)     ring_ret = bus_dat_o;
    else if (!bus_tag) ring_ret = poll_rep[sel_idx];
    else if (bus_we)  ring_ret = bus_dat_o;
    else              ring_ret = mem[sel_idx][bus_addr];
  end

  always @(posedge clk) begin
    if (sel_hit) begin
      if (m_stall) scnt <= scnt + 1;
      else begin
        scnt <= 0;
        if (bus_tag && acks_left > 0) begin
          acks_left <= acks_left - 1;
          if (bus_we) mem[sel_idx][bus_addr] <= bus_dat_o;
        end
        if (!bus_tag) poll_rep[sel_idx] <= 8'h00;
      end
    end else scnt <= 0;
  end

  // write stream
  logic [7:0] wq [256];
  int wlen = 0, wptr = 0;
  assign wr_valid = wptr < wlen;
  assign wr_data  = wq[wptr[7:0]];
  always @(posedge clk) if (wr_valid && wr_ready) wptr <= wptr + 1;

  // output capture
  logic [7:0] obuf [512];
  int olen = 0;
  always @(negedge clk) if (rst_n && rsp_valid && olen < 512) begin
    obuf[olen] = rsp_data;
    olen++;
  end

  // poll log
  bit plog_en = 0, plog_bad = 0;
  int plog [32];
  int pcnt = 0;
  always @(negedge clk) if (plog_en && (|bus_stb) && !bus_tag && pcnt < 32) begin
    plog[pcnt] = int'(sel_idx);
    pcnt++;
    if (bus_we || bus_addr != 8'h00) plog_bad = 1;
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic we, input logic incr, input logic [3:0] slot,
                          input logic [7:0] addr, input logic [7:0] len, output int waited);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = we; cmd_incr = incr;
    cmd_slot = slot; cmd_addr = addr; cmd_len = len;
    waited = 0;
    while (!cmd_ready) begin @(negedge clk); waited++; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_olen(input int n, input int limit);
    for (int i = 0; i < limit && olen < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    logic [7:0] expb [300];
    int elen, k, w, bad_i;
    logic [7:0] a;
    v = VECS[idx];
    k = (v.stall >= 16) ? 0 : ((v.len < v.ack) ? int'(v.len) : int'(v.ack));
    for (int i = 0; i < int'(v.len); i++) wq[i] = 8'(int'(v.addr) * 3 + i * 7 + int'(v.slot) + 1);
    expb[0] = {1'b1, v.we, v.incr, 1'b0, v.slot};
    expb[1] = v.addr;
    elen = 2;
    a = v.addr;
    for (int i = 0; i < k; i++) begin
      if (v.we) exp_mem[v.slot][a] = wq[i];
      else begin expb[elen] = exp_mem[v.slot][a]; elen++; end
      if (v.incr) a = a + 8'd1;
    end
    expb[elen] = 8'(k);
    elen++;
    @(negedge clk);
    stall_n = int'(v.stall); acks_left = int'(v.ack);
    wptr = 0; wlen = v.we ? int'(v.len) : 0;
    olen = 0;
    send_cmd(v.we, v.incr, v.slot, v.addr, v.len, w);
    wait_olen(elen, 3000);
    chk(olen == elen, {vtag[idx], " packet length"}, olen, elen);
    bad_i = -1;
    for (int i = 0; i < elen && i < olen; i++) if (bad_i < 0 && obuf[i] != expb[i]) bad_i = i;
    if (bad_i >= 0) chk(0, {vtag[idx], " packet byte"}, int'(obuf[bad_i]), int'(expb[bad_i]));
    else chk(1, vtag[idx], 0, 0);
    if (v.we) begin
      chk(wptr == int'(v.len), "R7 write bytes consumed", wptr, int'(v.len));
      bad_i = -1;
      for (int i = 0; i < 256; i++) if (bad_i < 0 && mem[v.slot][i] != exp_mem[v.slot][i]) bad_i = i;
      chk(bad_i < 0, "R1 slot memory after write", bad_i, -1);
    end
    stall_n = 0; acks_left = 255;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int w;
    bit seq_ok;
    for (int s = 0; s < NS; s++) begin
      poll_rep[s] = 8'h00;
      for (int a = 0; a < 256; a++) begin
        mem[s][a]     = 8'(s * 17 + a * 5 + 3);
        exp_mem[s][a] = 8'(s * 17 + a * 5 + 3);
      end
    end
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(bus_stb == '0, "R12 strobes idle in reset", int'(bus_stb), 0);
    chk(!rsp_valid, "R12 no output in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    chk(cmd_ready, "R12 command ready after reset", int'(cmd_ready), 1);

    // R2 round-robin polls
    pcnt = 0; plog_en = 1;
    for (int i = 0; i < 200 && pcnt < 20; i++) @(negedge clk);
    plog_en = 0;
    seq_ok = (pcnt >= 20) && !plog_bad;
    for (int i = 1; i < 20; i++) if (plog[i] != (plog[i-1] + 1) % NS) seq_ok = 0;
    chk(seq_ok, "R2 poll order and shape", pcnt, 20);

    // table
    for (int i = 0; i < NV; i++) run_vec(i);

    // R3 host priority over polling
    @(negedge clk);
    olen = 0;
    send_cmd(1'b0, 1'b1, 4'd2, 8'h05, 8'd1, w);
    chk(w <= 2, "R3 command waits at most one poll", w, 2);
    wait_olen(4, 500);
    chk(olen == 4 && obuf[2] == exp_mem[2][5], "R3 command served", int'(obuf[2]), int'(exp_mem[2][5]));

    // R9 auto-send
    @(negedge clk);
    olen = 0;
    poll_rep[11] = 8'd3;
    wait_olen(6, 400);
    chk(olen == 6 && obuf[0] == 8'h2B && obuf[1] == 8'h00 && obuf[5] == 8'd3,
        "R9 unsolicited header and count", int'(obuf[0]), 8'h2B);
    chk(obuf[2] == exp_mem[11][0] && obuf[3] == exp_mem[11][1] && obuf[4] == exp_mem[11][2],
        "R9 unsolicited data", int'(obuf[4]), int'(exp_mem[11][2]));

    // R10 abandoned poll
    @(negedge clk);
    stall_n = 20;
    olen = 0;
    poll_rep[4] = 8'd2;
    repeat (400) @(negedge clk);
    chk(olen == 0, "R10 stalled poll yields nothing", olen, 0);
    poll_rep[4] = 8'd0;
    stall_n = 0;
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end
endmodule